// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a flag-based condition holds. It also produces the two results that a conditional jump and a conditional byte-set need. A 4-bit condition code picks one of eight base tests on the overflow, carry, zero, sign and parity flags. The low bit of the code negates the chosen test. The evaluator registers three results: the one-bit verdict, a byte holding 0 or 1 for the set form, and the next instruction pointer for the branch form.

For the branch form the caller supplies the current instruction pointer, a displacement and an operand-size select. When the size select is low, only the low 16 bits of the displacement are used, sign-extended to 32 bits. A taken branch adds the displacement to the pointer, modulo 2^32. A branch that is not taken returns the pointer unchanged.

The caller pulses an input-valid strobe for one evaluation. The results appear one clock later with an output-valid strobe, and they hold until the next evaluation. Fetching instructions and producing the flags belong to neighbouring logic.

Top module: `cond_branch_eval`

## Requirements
- R1: While reset is asserted (rstN low), and right after it, outValid, condResult, setByte and nextIp are all zero.
- R2: outValid is high in exactly the cycle that follows each cycle in which inValid is high, and low otherwise.
- R3: condCode[3:1] selects the base test: 0 overflow, 1 carry, 2 zero, 3 carry or zero, 4 sign, 5 parity, 6 sign differs from overflow, 7 (sign differs from overflow) or zero.
- R4: When condCode[0] is 1, condResult is the inverse of the base test; when it is 0, condResult equals the base test.
- R5: setByte is 8'h01 when condResult is 1 and 8'h00 when it is 0.
- R6: With opSize32 = 1 and the condition true, nextIp = curIp + disp, wrapping modulo 2^32.
- R7: With opSize32 = 0, disp[31:16] are ignored, and disp[15:0] is sign-extended to 32 bits before it is added.
- R8: When the condition is false, nextIp equals curIp, whatever the displacement and size.
- R9: In a cycle with inValid low, condResult, setByte and nextIp keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | One-cycle request to evaluate |
| condCode | input | 4 | Condition code: [3:1] base test, [0] invert |
| flagOf | input | 1 | Overflow flag |
| flagCf | input | 1 | Carry flag |
| flagZf | input | 1 | Zero flag |
| flagSf | input | 1 | Sign flag |
| flagPf | input | 1 | Parity flag |
| curIp | input | 32 | Current instruction pointer |
| disp | input | 32 | Branch displacement |
| opSize32 | input | 1 | 1: 32-bit displacement, 0: sign-extended 16-bit |
| outValid | output | 1 | Results are fresh this cycle |
| condResult | output | 1 | Condition verdict |
| setByte | output | 8 | Byte result of the set form (0 or 1) |
| nextIp | output | 32 | Instruction pointer after the branch |

## Verification
The assertions check on every cycle that the valid strobe trails the request by one cycle, that the set byte matches the verdict, that an untaken branch returns the previous pointer, that a taken 32-bit branch adds the full displacement, and that idle cycles freeze the results. Only the bench's scenarios show the correctness of the condition table itself. The bench sweeps all sixteen codes against all thirty-two flag patterns. It also covers sign extension of negative short displacements, the disregard of the upper displacement bits in short mode, and wraparound past 2^32.

// File: rtl/cc_eval_pkg.sv
package ccEvalPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // load new results this cycle
    logic taken;    // condition holds
  } ccStrobe_t;

  // Base tests selected by the upper condition bits (order is behaviour)
  typedef enum logic [2:0] {
    BC_OVF      = 3'd0,
    BC_CARRY    = 3'd1,
    BC_ZERO     = 3'd2,
    BC_BELOW_EQ = 3'd3,
    BC_SIGN     = 3'd4,
    BC_PARITY   = 3'd5,
    BC_LESS     = 3'd6,
    BC_LESS_EQ  = 3'd7
  } baseCond_e;

endpackage

// File: rtl/cc_eval_ctrl.sv
module cc_eval_ctrl
  import ccEvalPkg::*;
#(
  parameter int COND_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [COND_W-1:0] condCode,
  input  logic              flagOf,
  input  logic              flagCf,
  input  logic              flagZf,
  input  logic              flagSf,
  input  logic              flagPf,
  output ccStrobe_t         strobe,
  output logic              outValid
);

  baseCond_e baseSel;
  logic      baseTrue;
  logic      signMismatch;

  assign baseSel      = baseCond_e'(condCode[COND_W-1:1]);
  assign signMismatch = flagSf ^ flagOf;

  always_comb begin
    unique case (baseSel)
      BC_OVF:      baseTrue = flagOf;
      BC_CARRY:    baseTrue = flagCf;
      BC_ZERO:     baseTrue = flagZf;
      BC_BELOW_EQ: baseTrue = flagCf | flagZf;
      BC_SIGN:     baseTrue = flagSf;
      BC_PARITY:   baseTrue = flagPf;
      BC_LESS:     baseTrue = signMismatch;
      BC_LESS_EQ:  baseTrue = signMismatch | flagZf;
      default:     baseTrue = 1'b0;
    endcase
  end

  always_comb begin
    strobe.capture = inValid;
    strobe.taken   = baseTrue ^ condCode[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/cc_eval_dp.sv
module cc_eval_dp
  import ccEvalPkg::*;
#(
  parameter int IP_W    = 32,
  parameter int SHORT_W = 16,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ccStrobe_t         strobe,
  input  logic [IP_W-1:0]   curIp,
  input  logic [IP_W-1:0]   disp,
  input  logic              opSize32,
  output logic              condResult,
  output logic [BYTE_W-1:0] setByte,
  output logic [IP_W-1:0]   nextIp
);

  localparam int EXT_W = IP_W - SHORT_W;

  logic [IP_W-1:0] dispShortExt;
  logic [IP_W-1:0] dispSel;
  logic [IP_W-1:0] ipSum;

  assign dispShortExt = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
  assign dispSel      = opSize32 ? disp : dispShortExt;
  assign ipSum        = curIp + dispSel;  // wraps modulo 2^IP_W

  always_ff @(posedge clk) begin
    if (!rstN) begin
      condResult <= 1'b0;
      setByte    <= '0;
      nextIp     <= '0;
    end else if (strobe.capture) begin
      condResult <= strobe.taken;
      setByte    <= {{(BYTE_W-1){1'b0}}, strobe.taken};
      nextIp     <= strobe.taken ? ipSum : curIp;
    end
  end

endmodule

// File: rtl/cond_branch_eval.sv
module cond_branch_eval
  import ccEvalPkg::*;
#(
  parameter int COND_W  = 4,
  parameter int IP_W    = 32,
  parameter int SHORT_W = 16,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [COND_W-1:0] condCode,
  input  logic              flagOf,
  input  logic              flagCf,
  input  logic              flagZf,
  input  logic              flagSf,
  input  logic              flagPf,
  input  logic [IP_W-1:0]   curIp,
  input  logic [IP_W-1:0]   disp,
  input  logic              opSize32,
  output logic              outValid,
  output logic              condResult,
  output logic [BYTE_W-1:0] setByte,
  output logic [IP_W-1:0]   nextIp
);

  ccStrobe_t strobe;

  cc_eval_ctrl #(.COND_W(COND_W)) ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .condCode(condCode),
    .flagOf(flagOf), .flagCf(flagCf), .flagZf(flagZf), .flagSf(flagSf),
    .flagPf(flagPf), .strobe(strobe), .outValid(outValid)
  );

  cc_eval_dp #(.IP_W(IP_W), .SHORT_W(SHORT_W), .BYTE_W(BYTE_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curIp(curIp), .disp(disp),
    .opSize32(opSize32), .condResult(condResult), .setByte(setByte),
    .nextIp(nextIp)
  );

endmodule

// File: rtl/cc_eval_check.sv
module cc_eval_check #(
  parameter int COND_W  = 4,
  parameter int IP_W    = 32,
  parameter int BYTE_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [COND_W-1:0] condCode,
  input logic [IP_W-1:0]   curIp,
  input logic [IP_W-1:0]   disp,
  input logic              opSize32,
  input logic              outValid,
  input logic              condResult,
  input logic [BYTE_W-1:0] setByte,
  input logic [IP_W-1:0]   nextIp
);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_set_byte_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (setByte == {{(BYTE_W-1){1'b0}}, condResult}));

  assert_full_disp_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && condResult && $past(opSize32)) |->
      (nextIp == $past(curIp) + $past(disp)));

  assert_not_taken_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !condResult) |-> (nextIp == $past(curIp)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(nextIp) && $stable(condResult) && $stable(setByte)));

endmodule

bind cond_branch_eval cc_eval_check #(.COND_W(COND_W), .IP_W(IP_W), .BYTE_W(BYTE_W)) chk (.*);

// File: tb/cond_branch_eval_test.sv
module cond_branch_eval_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  condCode = '0;
  logic        flagOf = 0, flagCf = 0, flagZf = 0, flagSf = 0, flagPf = 0;
  logic [31:0] curIp = '0;
  logic [31:0] disp = '0;
  logic        opSize32 = 1'b0;
  logic        outValid;
  logic        condResult;
  logic [7:0]  setByte;
  logic [31:0] nextIp;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cond_branch_eval uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .condCode(condCode),
    .flagOf(flagOf), .flagCf(flagCf), .flagZf(flagZf), .flagSf(flagSf),
    .flagPf(flagPf), .curIp(curIp), .disp(disp), .opSize32(opSize32),
    .outValid(outValid), .condResult(condResult), .setByte(setByte),
    .nextIp(nextIp)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Truth from the requirement table: flags packed {of,cf,zf,sf,pf}
  function automatic bit refCond(input logic [3:0] code, input logic [4:0] f);
    bit o = f[4], c = f[3], z = f[2], s = f[1], p = f[0];
    bit b;
    case (code[3:1])
      3'd0: b = o;
      3'd1: b = c;
      3'd2: b = z;
      3'd3: b = c || z;
      3'd4: b = s;
      3'd5: b = p;
      3'd6: b = (s != o);
      default: b = (s != o) || z;
    endcase
    return code[0] ? !b : b;
  endfunction

  function automatic logic [31:0] refIp(input bit taken, input logic [31:0] ip,
                                        input logic [31:0] d, input bit wide);
    longint unsigned sum;
    logic [31:0] eff;
    if (!taken) return ip;
    eff = wide ? d : (d[15] ? (32'hFFFF0000 | d[15:0]) : {16'h0, d[15:0]});
    sum = (longint'(ip) + longint'(eff)) % 64'h1_0000_0000;
    return sum[31:0];
  endfunction

  task automatic evalOnce(input logic [3:0] code, input logic [4:0] f,
                          input logic [31:0] ip, input logic [31:0] d, input bit wide);
    bit exp;
    @(negedge clk);
    inValid = 1'b1; condCode = code;
    {flagOf, flagCf, flagZf, flagSf, flagPf} = f;
    curIp = ip; disp = d; opSize32 = wide;
    @(negedge clk);
    inValid = 1'b0;
    exp = refCond(code, f);
    check("R2 outValid", {31'b0, outValid}, 32'd1);
    check(code[0] ? "R4 inverted result" : "R3 base result", {31'b0, condResult}, {31'b0, exp});
    check("R5 setByte", {24'b0, setByte}, exp ? 32'd1 : 32'd0);
    if (exp)
      check(wide ? "R6 taken ip" : "R7 short disp ip", nextIp, refIp(1'b1, ip, d, wide));
    else
      check("R8 untaken ip", nextIp, ip);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] heldIp;
    logic        heldRes;
    repeat (3) @(negedge clk);
    check("R1 reset outValid", {31'b0, outValid}, 32'd0);
    check("R1 reset condResult", {31'b0, condResult}, 32'd0);
    check("R1 reset setByte", {24'b0, setByte}, 32'd0);
    check("R1 reset nextIp", nextIp, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset nextIp", nextIp, 32'd0);
    check("R2 idle outValid", {31'b0, outValid}, 32'd0);

    // Exhaustive sweep of codes and flag patterns, R3 R4 R5 R6 R7 R8
    for (int code = 0; code < 16; code++) begin
      for (int f = 0; f < 32; f++) begin
        logic [31:0] ip = 32'h1000_0000 + code * 32'h0001_1111 + f * 32'd4567;
        logic [31:0] d  = (f[0] ? 32'hFFF0_8000 : 32'h0002_3456) + f * 32'd37;
        evalOnce(code[3:0], f[4:0], ip, d, bit'(code[0] ^ f[1]));
      end
    end

    // R6 wraparound
    evalOnce(4'b0001, 5'b00000, 32'hFFFF_FFF0, 32'h0000_0020, 1'b1);
    check("R6 wrap value", nextIp, 32'h0000_0010);
    // R7 negative short displacement
    evalOnce(4'b0100, 5'b00100, 32'h0000_1000, 32'hABCD_FFFE, 1'b0);
    check("R7 negative short", nextIp, 32'h0000_0FFE);
    // R7 upper bits ignored for positive short displacement
    evalOnce(4'b0100, 5'b00100, 32'h0000_1000, 32'hFFFF_0010, 1'b0);
    check("R7 upper disp ignored", nextIp, 32'h0000_1010);
    // R8 untaken ignores a large displacement
    evalOnce(4'b0101, 5'b00100, 32'h1234_5678, 32'h7FFF_FFFF, 1'b1);
    check("R8 untaken hold", nextIp, 32'h1234_5678);

    // R9 idle cycles with wild inputs leave results unchanged
    evalOnce(4'b0010, 5'b00100, 32'h0000_4000, 32'h0000_0100, 1'b1);
    heldIp = nextIp; heldRes = condResult;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      condCode = 4'(k * 5); {flagOf, flagCf, flagZf, flagSf, flagPf} = 5'(k * 7);
      curIp = 32'hDEAD_0000 + k; disp = 32'h0BAD_0000 + k; opSize32 = k[0];
      check("R9 hold nextIp", nextIp, heldIp);
      check("R9 hold condResult", {31'b0, condResult}, {31'b0, heldRes});
      check("R2 no valid when idle", {31'b0, outValid}, 32'd0);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule